// File: doc/BRIEF.md
# Flash Reset and Block Write-Protect Controller

This block is the control core of a flash memory divided into sixteen equal blocks. It sets the device mode and decides whether each program or block-erase request may go ahead. Two active-low reset inputs, one from the interface side and one from the processor side, are merged into a single internal reset. While that reset is active, the block tristates the data outputs, relocks every block and samples the interface-mode select. When reset ends, it places the array in read mode and holds the sampled interface mode until the next reset.

Each program or erase request is checked against a one-bit lock register for the target block and against a hardware pin that guards only the top block. When that pin is low, it overrides the top block's lock register. A request that passes is granted and starts an operation. The block stays busy until a done input reports that the operation has completed. A request that fails, or that arrives while an operation is running, is ignored and changes nothing. Every request produces a one-cycle result pulse, either granted or ignored.

Top module: `flash_guard_ctrl`

## Requirements
- R1: The internal reset is active whenever `ext_rst_n` or `cpu_rst_n` is low. It is inactive only when both are high.
- R2: `out_en` is 0 in the cycle after any clock edge that sees the internal reset active. It is 1 after any edge that sees the internal reset inactive, so the data outputs are high impedance during reset.
- R3: On the first clock edge after the internal reset is released, the state becomes read mode, and `read_mode` reads 1 from then on until a request is granted.
- R4: `mode_mux` copies `mode_sel` at every clock edge with the internal reset active. A value of 0 (low or undriven) selects the hub interface and 1 selects the multiplexed-address interface. Outside reset, `mode_mux` holds its value and changes on `mode_sel` are ignored.
- R5: A request to block 15 is ignored while `top_lock_n` is 0, whatever that block's lock bit holds.
- R6: While `top_lock_n` is 1, a request to block 15 is granted or ignored only according to its lock bit, where 1 means locked.
- R7: For blocks 0 to 14, the outcome of a request depends only on that block's lock bit, never on `top_lock_n`.
- R8: Reset sets every lock bit to 1 (locked). A write through `lk_we`/`lk_blk`/`lk_val` takes effect only when the block is outside reset and not busy. A write made while busy is ignored.
- R9: Each cycle with `req_valid` high, when not in reset, yields exactly one of `grant` or `ignore`, high for one cycle after the next clock edge. `req_kind` 0 means program and 1 means block erase. Both kinds are checked the same way.
- R10: A granted request sets `busy` after the same edge, and `busy` holds until an edge with `done` high. A request that arrives while busy is ignored.
- R11: The `top_lock_n` level is captured when an operation is granted and held until it completes. Changing the pin while busy neither ends the operation nor alters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | Interface reset, active low |
| cpu_rst_n | input | 1 | Processor reset, active low |
| mode_sel | input | 1 | Interface-mode select, sampled during reset |
| top_lock_n | input | 1 | Top-block hardware lock, low protects block 15 |
| req_valid | input | 1 | Program/erase request strobe |
| req_blk | input | 4 | Target block of the request |
| req_kind | input | 1 | 0 program, 1 block erase |
| done | input | 1 | Running operation has completed |
| lk_we | input | 1 | Lock-bit write strobe |
| lk_blk | input | 4 | Block whose lock bit is written |
| lk_val | input | 1 | New lock bit, 1 locked |
| mode_mux | output | 1 | Held interface mode, 1 multiplexed-address |
| read_mode | output | 1 | Array is in read mode |
| busy | output | 1 | An operation is in progress |
| grant | output | 1 | One-cycle pulse, request accepted |
| ignore | output | 1 | One-cycle pulse, request ignored |
| out_en | output | 1 | Data output enable, 0 means high impedance |

## Verification
Every output is a register, so each result appears right after the first clock edge that sees its cause. `out_en`, `mode_mux` and `read_mode` follow the reset inputs one edge later. `grant` or `ignore` and the rise of `busy` follow a request one edge later, and `busy` falls one edge after `done`. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. It then samples one edge further to confirm that each result pulse has ended. It sweeps all 16 blocks under both pin levels and several lock patterns, computing the expected outcome arithmetically.

// File: rtl/fguard_pkg.sv
package fguard_pkg;
  typedef enum logic [1:0] {
    FG_RESET = 2'd0,
    FG_READ  = 2'd1,
    FG_BUSY  = 2'd2
  } fg_state_e;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } fg_op_e;
endpackage

// File: rtl/fg_reset_ctrl.sv
module fg_reset_ctrl (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic cpu_rst_n,
  input  logic mode_sel,
  output logic rst_int,
  output logic mode_mux_q,
  output logic out_en_q
);
  // R1: either active-low source asserts the merged reset
  assign rst_int = !(ext_rst_n && cpu_rst_n);

  // R4: mode select is transparent only during reset
  always_ff @(posedge clk) begin
    if (rst_int) mode_mux_q <= mode_sel;
  end

  // R2: outputs disabled while reset is seen at an edge
  always_ff @(posedge clk) begin
    out_en_q <= !rst_int;
  end
endmodule

// File: rtl/fg_lock_bank.sv
module fg_lock_bank #(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_int,
  input  logic                  wr_allow,
  input  logic                  wr_en,
  input  logic [BLK_W-1:0]      wr_blk,
  input  logic                  wr_val,
  output logic [NUM_BLOCKS-1:0] locks
);
  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_lock
    logic hit;
    assign hit = wr_allow && wr_en && (wr_blk == BLK_W'(i));
    // R8: relocked by reset, writable only outside reset and busy
    always_ff @(posedge clk) begin
      if (rst_int)  locks[i] <= 1'b1;
      else if (hit) locks[i] <= wr_val;
    end
  end
endmodule

// File: rtl/fg_op_arbiter.sv
module fg_op_arbiter
  import fguard_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int TOP_BLK = NUM_BLOCKS - 1
) (
  input  logic                  clk,
  input  logic                  rst_int,
  input  logic                  req_valid,
  input  logic [BLK_W-1:0]      req_blk,
  input  logic                  req_kind,
  input  logic                  top_lock_n,
  input  logic                  done,
  input  logic [NUM_BLOCKS-1:0] locks,
  output fg_state_e             state_q,
  output logic                  grant_q,
  output logic                  ignore_q,
  output logic [BLK_W-1:0]      op_blk_q,
  output fg_op_e                op_kind_q,
  output logic                  op_tlk_q
);
  logic lock_bit;
  logic top_hit;
  logic blocked;
  logic accept;

  always_comb begin
    lock_bit = 1'b1;
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      if (req_blk == BLK_W'(b)) lock_bit = locks[b];
    end
  end

  // R5 R6 R7: pin covers only the top block and overrides its lock bit
  assign top_hit = (req_blk == BLK_W'(TOP_BLK));
  assign blocked = lock_bit || (top_hit && !top_lock_n);
  // R10: no new operation while one runs
  assign accept  = req_valid && (state_q != FG_BUSY) && !blocked;

  always_ff @(posedge clk) begin
    if (rst_int) begin
      state_q <= FG_RESET;
    end else if (accept) begin
      state_q <= FG_BUSY;
    end else if (state_q == FG_BUSY) begin
      if (done) state_q <= FG_READ;
    end else begin
      state_q <= FG_READ; // R3
    end
  end

  // R9: one result pulse per request
  always_ff @(posedge clk) begin
    grant_q  <= !rst_int && accept;
    ignore_q <= !rst_int && req_valid && !accept;
  end

  // R11: operation record captured at grant
  always_ff @(posedge clk) begin
    if (rst_int) begin
      op_blk_q  <= '0;
      op_kind_q <= OP_PROGRAM;
      op_tlk_q  <= 1'b0;
    end else if (accept) begin
      op_blk_q  <= req_blk;
      op_kind_q <= fg_op_e'(req_kind);
      op_tlk_q  <= top_lock_n;
    end
  end
endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import fguard_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             ext_rst_n,
  input  logic             cpu_rst_n,
  input  logic             mode_sel,
  input  logic             top_lock_n,
  input  logic             req_valid,
  input  logic [BLK_W-1:0] req_blk,
  input  logic             req_kind,
  input  logic             done,
  input  logic             lk_we,
  input  logic [BLK_W-1:0] lk_blk,
  input  logic             lk_val,
  output logic             mode_mux,
  output logic             read_mode,
  output logic             busy,
  output logic             grant,
  output logic             ignore,
  output logic             out_en
);
  logic                  rst_int;
  logic [NUM_BLOCKS-1:0] locks;
  fg_state_e             state_q;
  logic [BLK_W-1:0]      op_blk_q;
  fg_op_e                op_kind_q;
  logic                  op_tlk_q;

  fg_reset_ctrl u_rst (
    .clk        (clk),
    .ext_rst_n  (ext_rst_n),
    .cpu_rst_n  (cpu_rst_n),
    .mode_sel   (mode_sel),
    .rst_int    (rst_int),
    .mode_mux_q (mode_mux),
    .out_en_q   (out_en)
  );

  fg_lock_bank #(.NUM_BLOCKS(NUM_BLOCKS)) u_locks (
    .clk      (clk),
    .rst_int  (rst_int),
    .wr_allow (state_q != FG_BUSY),
    .wr_en    (lk_we),
    .wr_blk   (lk_blk),
    .wr_val   (lk_val),
    .locks    (locks)
  );

  fg_op_arbiter #(.NUM_BLOCKS(NUM_BLOCKS)) u_arb (
    .clk        (clk),
    .rst_int    (rst_int),
    .req_valid  (req_valid),
    .req_blk    (req_blk),
    .req_kind   (req_kind),
    .top_lock_n (top_lock_n),
    .done       (done),
    .locks      (locks),
    .state_q    (state_q),
    .grant_q    (grant),
    .ignore_q   (ignore),
    .op_blk_q   (op_blk_q),
    .op_kind_q  (op_kind_q),
    .op_tlk_q   (op_tlk_q)
  );

  assign busy      = (state_q == FG_BUSY);
  assign read_mode = (state_q == FG_READ);
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int BLK_W = 4,
  parameter int TOP_BLK = 15
) (
  input logic             clk,
  input logic             rst_int,
  input logic             req_valid,
  input logic [BLK_W-1:0] req_blk,
  input logic             top_lock_n,
  input logic             done,
  input logic             mode_mux,
  input logic             read_mode,
  input logic             busy,
  input logic             grant,
  input logic             ignore,
  input logic             out_en,
  input logic             op_tlk_q
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  AST_OE_OFF_IN_RESET: assert property (@(posedge clk) disable iff (!started)
    rst_int |=> !out_en); // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!started)
    !rst_int |=> $stable(mode_mux)); // R4
  AST_READ_AFTER_RESET: assert property (@(posedge clk) disable iff (!started)
    rst_int ##1 !rst_int |=> read_mode); // R3
  AST_TOP_PIN_BLOCKS: assert property (@(posedge clk) disable iff (rst_int)
    req_valid && (req_blk == BLK_W'(TOP_BLK)) && !top_lock_n |=> !grant); // R5
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst_int)
    $onehot0({grant, ignore})); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst_int)
    busy && !done |=> busy); // R10
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst_int)
    busy && req_valid |=> ignore); // R10
  AST_TLK_CAPTURED: assert property (@(posedge clk) disable iff (rst_int)
    busy && !done |=> $stable(op_tlk_q)); // R11
endmodule

bind flash_guard_ctrl fg_checker #(.BLK_W(BLK_W), .TOP_BLK(NUM_BLOCKS - 1)) u_chk (
  .clk        (clk),
  .rst_int    (rst_int),
  .req_valid  (req_valid),
  .req_blk    (req_blk),
  .top_lock_n (top_lock_n),
  .done       (done),
  .mode_mux   (mode_mux),
  .read_mode  (read_mode),
  .busy       (busy),
  .grant      (grant),
  .ignore     (ignore),
  .out_en     (out_en),
  .op_tlk_q   (op_tlk_q)
);

// File: tb/tb_flash_guard_ctrl.sv
`timescale 1ns/1ps
module tb_flash_guard_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic ext_rst_n, cpu_rst_n, mode_sel, top_lock_n;
  logic req_valid, req_kind, done, lk_we, lk_val;
  logic [3:0] req_blk, lk_blk;
  logic mode_mux, read_mode, busy, grant, ignore, out_en;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_guard_ctrl dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .cpu_rst_n(cpu_rst_n),
    .mode_sel(mode_sel), .top_lock_n(top_lock_n), .req_valid(req_valid),
    .req_blk(req_blk), .req_kind(req_kind), .done(done), .lk_we(lk_we),
    .lk_blk(lk_blk), .lk_val(lk_val), .mode_mux(mode_mux),
    .read_mode(read_mode), .busy(busy), .grant(grant), .ignore(ignore),
    .out_en(out_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_lock(input int b, input logic v);
    @(negedge clk); lk_we = 1'b1; lk_blk = 4'(b); lk_val = v;
    @(negedge clk); lk_we = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk); done = 1'b1;
    tick();
    chk("R10 busy clears on done", busy, 1'b0);
    @(negedge clk); done = 1'b0;
  endtask

  task automatic do_req(input int b, input logic kind, input logic exp, input string tag);
    @(negedge clk); req_valid = 1'b1; req_blk = 4'(b); req_kind = kind;
    tick();
    chk(tag, grant, exp);
    chk("R9 ignore complements grant", ignore, !exp);
    @(negedge clk); req_valid = 1'b0;
    tick();
    chk("R9 single-cycle pulse", grant | ignore, 1'b0);
    if (exp) begin
      chk("R10 busy after grant", busy, 1'b1);
      finish_op();
    end
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk); cpu_rst_n = 1'b0; mode_sel = sel;
    tick(); tick();
    @(negedge clk); cpu_rst_n = 1'b1; mode_sel = !sel;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ext_rst_n = 1'b0; cpu_rst_n = 1'b0; mode_sel = 1'b0; top_lock_n = 1'b1;
    req_valid = 1'b0; req_kind = 1'b0; req_blk = '0; done = 1'b0;
    lk_we = 1'b0; lk_blk = '0; lk_val = 1'b0;
    tick();
    chk("R2 out_en low in reset", out_en, 1'b0);

    // R1 R2 R3: every combination of the two reset inputs
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ext_rst_n = i[0]; cpu_rst_n = i[1];
      tick();
      chk("R1 R2 out_en vs merged reset", out_en, logic'(i == 3));
      if (i == 3) chk("R3 read mode after release", read_mode, 1'b1);
    end

    // R4: mode sampled in reset, held after
    for (int s = 0; s < 2; s++) begin
      do_reset(logic'(s));
      chk("R4 mode latched", mode_mux, logic'(s));
      chk("R3 read mode after release", read_mode, 1'b1);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); mode_sel = ~mode_sel;
        tick();
        chk("R4 mode select ignored outside reset", mode_mux, logic'(s));
      end
    end

    // R8: all blocks locked after reset
    for (int b = 0; b < NB; b++) do_req(b, 1'b0, 1'b0, "R8 locked after reset");

    // R5 R6 R7 R9: sweep pin level, lock pattern and block
    for (int tl = 0; tl < 2; tl++) begin
      for (int pat = 0; pat < 3; pat++) begin
        @(negedge clk); top_lock_n = logic'(tl);
        for (int b = 0; b < NB; b++) set_lock(b, logic'(((b + pat) % 3) == 0));
        for (int b = 0; b < NB; b++) begin
          logic lk;
          logic exp;
          lk  = logic'(((b + pat) % 3) == 0);
          exp = !lk && !(b == NB-1 && tl == 0);
          if (b == NB-1 && tl == 0) do_req(b, logic'(b % 2), exp, "R5 top pin low blocks top");
          else if (b == NB-1)       do_req(b, logic'(b % 2), exp, "R6 top follows lock bit");
          else                      do_req(b, logic'(b % 2), exp, "R7 lower blocks by lock bit");
        end
      end
    end

    // R10 R11 R8: behaviour while busy
    @(negedge clk); top_lock_n = 1'b1;
    set_lock(3, 1'b0);
    set_lock(5, 1'b0);
    @(negedge clk); req_valid = 1'b1; req_blk = 4'd3; req_kind = 1'b1;
    tick();
    chk("R10 grant starts op", grant, 1'b1);
    @(negedge clk); req_valid = 1'b0; top_lock_n = 1'b0;
    tick();
    chk("R11 pin change keeps op running", busy, 1'b1);
    set_lock(3, 1'b1);
    @(negedge clk); req_valid = 1'b1; req_blk = 4'd5;
    tick();
    chk("R10 request while busy ignored", ignore, 1'b1);
    chk("R10 busy held", busy, 1'b1);
    @(negedge clk); req_valid = 1'b0; top_lock_n = 1'b1;
    finish_op();
    do_req(3, 1'b0, 1'b1, "R8 lock write while busy ignored");
    do_req(5, 1'b0, 1'b1, "R10 ignored request left state unchanged");

    // R8 R1: processor reset alone relocks
    @(negedge clk); cpu_rst_n = 1'b0;
    tick();
    chk("R1 cpu reset alone", out_en, 1'b0);
    @(negedge clk); cpu_rst_n = 1'b1;
    tick();
    do_req(3, 1'b0, 1'b0, "R8 reset relocks");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule